// File: doc/BRIEF.md
# PWM Compare Shadow-Update Controller

This block is the register front end of a two-channel PWM timer. Software writes four compare values (set and clear edges for waveform A and for waveform B) through a byte-wide register bus into shadow registers. The timer core keeps running on the active copies, so it never sees a half-written value. A synchronization request arms a transfer. On the next cycle-end strobe from the counter, all four shadow values move into the active registers in a single clock.

A control byte adds several features. A fifty-percent mode mirrors every compare write into both channels. An auto-update mode arms the transfer when the high byte of a clear value is written. Two select bits route outputs C and D from either waveform. An override bit drives outputs A and B from software-written levels instead of the waveform generator. A second control byte holds those override levels and a write-only synchronization strobe.

Register map (4-bit byte address): 0x0 control, 0x1 force/strobe, then one low/high byte pair per compare value. The pairs are set-A at 0x2/0x3, set-B at 0x4/0x5, clear-A at 0x6/0x7 and clear-B at 0x8/0x9. In each pair the low byte sits at the lower address. Unmapped addresses read zero.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: After reset, all registers read zero, all active compare outputs are zero, no transfer is pending, and outputs A/B/C/D follow waveform A, B, A, A.
- R2: Each compare value is CMP_W (12) bits. The low byte holds bits 7:0 and the high byte holds bits 11:8 in its bits 3:0. Readback returns the shadow value, and the unused high-byte bits read zero.
- R3: Shadow writes do not change the active compare outputs until a pending request meets a cycle-end strobe.
- R4: A cycle-end strobe while a request is pending copies all four shadow values to the active outputs, visible after that clock edge, and clears the request. A strobe with no request pending changes nothing.
- R5: Writing 0x1 with bit 7 set arms a transfer. That bit reads back as zero.
- R6: With control bit 1 (auto-update) set, writing the clear-B high byte (0x9) arms a transfer. Low-byte writes do not arm one. Writing the clear-A high byte does not arm one while bit 3 is clear.
- R7: With control bits 1 and 3 both set, writing the clear-A high byte (0x7) also arms a transfer.
- R8: With control bit 3 (fifty-percent) set, a write to either set register's low or high byte lands in both set-A and set-B. With bit 3 clear, it lands only in the addressed one.
- R9: With control bit 3 set, a write to either clear register's byte lands in both clear-A and clear-B.
- R10: Control bit 6 routes output C from waveform A (0) or B (1). Control bit 7 does the same for output D.
- R11: With control bit 0 set, outputs A and B take the levels of bits 0 and 1 of register 0x1 instead of the waveform inputs.
- R12: Control bits 5, 4 and 2 ignore writes and read zero. The other control bits read back as written.
- R13: If a new request is made on the same edge that a pending request meets a cycle-end strobe, the transfer happens and the new request stays pending for the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| cycle_end_i | input | 1 | One-clock strobe at end of timer cycle |
| wave_a_i | input | 1 | Raw waveform A from generator |
| wave_b_i | input | 1 | Raw waveform B from generator |
| act_set_a_o | output | CMP_W | Active set compare, waveform A |
| act_set_b_o | output | CMP_W | Active set compare, waveform B |
| act_clr_a_o | output | CMP_W | Active clear compare, waveform A |
| act_clr_b_o | output | CMP_W | Active clear compare, waveform B |
| out_a_o | output | 1 | Output pin A |
| out_b_o | output | 1 | Output pin B |
| out_c_o | output | 1 | Output pin C |
| out_d_o | output | 1 | Output pin D |

## Verification
The bench builds the block with its defaults, ADDR_W = 4 and CMP_W = 12. The 12-bit width leaves four unused bits in every high byte, so the masking of those bits on readback and transfer can be seen. The 4-bit address covers the whole map, including unmapped locations. Each scenario starts from a fresh reset, so the arming sources (strobe, auto-update on either clear high byte, and a request on the same edge as a cycle end) are each seen in isolation.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int unsigned N_CMP = 4;

  localparam int ADR_CTL  = 0;
  localparam int ADR_FRC  = 1;
  localparam int ADR_CMP0 = 2;

  localparam int CH_SET_A = 0;
  localparam int CH_SET_B = 1;
  localparam int CH_CLR_A = 2;
  localparam int CH_CLR_B = 3;

  localparam int B_DSEL  = 7;
  localparam int B_CSEL  = 6;
  localparam int B_FIFTY = 3;
  localparam int B_AUTO  = 1;
  localparam int B_OVR   = 0;
  localparam int B_FRC_A = 0;
  localparam int B_FRC_B = 1;
  localparam int B_SYNC  = 7;

  typedef struct packed {
    logic dsel;
    logic csel;
    logic fifty;
    logic auto_upd;
    logic ovr;
    logic frc_a;
    logic frc_b;
  } ctl_t;

  function automatic int lo_adr(input int ch);
    return ADR_CMP0 + 2 * ch;
  endfunction

  function automatic int hi_adr(input int ch);
    return ADR_CMP0 + 2 * ch + 1;
  endfunction
endpackage

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
  import pwm_shadow_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              cycle_end_i,
  output ctl_t              ctl_o,
  output logic [7:0]        rdata_o,
  output logic              copy_o
);
  localparam logic [ADDR_W-1:0] A_CTL    = ADDR_W'(ADR_CTL);
  localparam logic [ADDR_W-1:0] A_FRC    = ADDR_W'(ADR_FRC);
  localparam logic [ADDR_W-1:0] A_CLRAHI = ADDR_W'(hi_adr(CH_CLR_A));
  localparam logic [ADDR_W-1:0] A_CLRBHI = ADDR_W'(hi_adr(CH_CLR_B));

  ctl_t ctl_q;
  logic pending_q;
  logic sel_ctl, sel_frc;
  logic req_sw, req_auto, req;

  assign sel_ctl = (addr_i == A_CTL);
  assign sel_frc = (addr_i == A_FRC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (wr_en_i) begin
      if (sel_ctl) begin
        ctl_q.dsel     <= wdata_i[B_DSEL];
        ctl_q.csel     <= wdata_i[B_CSEL];
        ctl_q.fifty    <= wdata_i[B_FIFTY];
        ctl_q.auto_upd <= wdata_i[B_AUTO];
        ctl_q.ovr      <= wdata_i[B_OVR];
      end
      if (sel_frc) begin
        ctl_q.frc_a <= wdata_i[B_FRC_A];
        ctl_q.frc_b <= wdata_i[B_FRC_B];
      end
    end
  end

  // request sources: software strobe, auto-update on clear high byte
  assign req_sw   = wr_en_i && sel_frc && wdata_i[B_SYNC];
  assign req_auto = wr_en_i && ctl_q.auto_upd &&
                    ((addr_i == A_CLRBHI) || (ctl_q.fifty && (addr_i == A_CLRAHI)));
  assign req      = req_sw || req_auto;
  assign copy_o   = pending_q && cycle_end_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pending_q <= 1'b0;
    else         pending_q <= (pending_q && !cycle_end_i) || req;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctl) begin
      rdata_o[B_DSEL]  = ctl_q.dsel;
      rdata_o[B_CSEL]  = ctl_q.csel;
      rdata_o[B_FIFTY] = ctl_q.fifty;
      rdata_o[B_AUTO]  = ctl_q.auto_upd;
      rdata_o[B_OVR]   = ctl_q.ovr;
    end
    if (sel_frc) begin
      rdata_o[B_FRC_A] = ctl_q.frc_a;
      rdata_o[B_FRC_B] = ctl_q.frc_b;
    end
  end

  assign ctl_o = ctl_q;

  AST_SYNC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && cycle_end_i && !req) |=> !pending_q); // R4
  AST_STROBE_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_frc && wdata_i[B_SYNC]) |=> pending_q); // R5
  AST_AUTO_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ctl_q.auto_upd && addr_i == A_CLRBHI) |=> pending_q); // R6
  AST_KEEP_NEW_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy_o && req) |=> pending_q); // R13
endmodule

// File: rtl/pwm_cmp_shadow.sv
module pwm_cmp_shadow
  import pwm_shadow_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CMP_W  = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [7:0]                    wdata_i,
  input  logic                          fifty_i,
  input  logic                          copy_i,
  output logic [N_CMP-1:0][CMP_W-1:0]   act_o,
  output logic [7:0]                    rdata_o
);
  localparam int HI_W = CMP_W - 8;

  logic [N_CMP-1:0][7:0]      shd_lo_q;
  logic [N_CMP-1:0][HI_W-1:0] shd_hi_q;
  logic [N_CMP-1:0][CMP_W-1:0] act_q;

  for (genvar ch = 0; ch < N_CMP; ch++) begin : g_ch
    localparam int PEER = ch ^ 1;
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(lo_adr(ch));
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(hi_adr(ch));
    localparam logic [ADDR_W-1:0] P_LO  = ADDR_W'(lo_adr(PEER));
    localparam logic [ADDR_W-1:0] P_HI  = ADDR_W'(hi_adr(PEER));

    logic lo_hit, hi_hit;
    // fifty mode: peer channel address also writes this one
    assign lo_hit = wr_en_i && ((addr_i == A_LO) || (fifty_i && addr_i == P_LO));
    assign hi_hit = wr_en_i && ((addr_i == A_HI) || (fifty_i && addr_i == P_HI));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shd_lo_q[ch] <= '0;
        shd_hi_q[ch] <= '0;
      end else begin
        if (lo_hit) shd_lo_q[ch] <= wdata_i;
        if (hi_hit) shd_hi_q[ch] <= wdata_i[HI_W-1:0];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     act_q[ch] <= '0;
      else if (copy_i) act_q[ch] <= {shd_hi_q[ch], shd_lo_q[ch]};
    end

    AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !copy_i |=> $stable(act_q[ch])); // R3
    AST_ACT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      copy_i |=> act_q[ch] == $past({shd_hi_q[ch], shd_lo_q[ch]})); // R4
    AST_MIRROR_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && fifty_i && addr_i == P_LO) |=> shd_lo_q[ch] == $past(wdata_i)); // R8 R9
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < N_CMP; c++) begin
      if (addr_i == ADDR_W'(lo_adr(c))) rdata_o = rdata_o | shd_lo_q[c];
      if (addr_i == ADDR_W'(hi_adr(c))) rdata_o = rdata_o | 8'(shd_hi_q[c]);
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/pwm_out_mux.sv
module pwm_out_mux
  import pwm_shadow_pkg::*;
(
  input  ctl_t ctl_i,
  input  logic wave_a_i,
  input  logic wave_b_i,
  output logic out_a_o,
  output logic out_b_o,
  output logic out_c_o,
  output logic out_d_o
);
  assign out_a_o = ctl_i.ovr  ? ctl_i.frc_a : wave_a_i;
  assign out_b_o = ctl_i.ovr  ? ctl_i.frc_b : wave_b_i;
  assign out_c_o = ctl_i.csel ? wave_b_i    : wave_a_i;
  assign out_d_o = ctl_i.dsel ? wave_b_i    : wave_a_i;
endmodule

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl
  import pwm_shadow_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CMP_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              cycle_end_i,
  input  logic              wave_a_i,
  input  logic              wave_b_i,
  output logic [CMP_W-1:0]  act_set_a_o,
  output logic [CMP_W-1:0]  act_set_b_o,
  output logic [CMP_W-1:0]  act_clr_a_o,
  output logic [CMP_W-1:0]  act_clr_b_o,
  output logic              out_a_o,
  output logic              out_b_o,
  output logic              out_c_o,
  output logic              out_d_o
);
  ctl_t ctl;
  logic copy;
  logic [7:0] ctl_rdata, cmp_rdata;
  logic [N_CMP-1:0][CMP_W-1:0] act;

  pwm_ctrl_regs #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .cycle_end_i(cycle_end_i),
    .ctl_o(ctl), .rdata_o(ctl_rdata), .copy_o(copy)
  );

  pwm_cmp_shadow #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .fifty_i(ctl.fifty), .copy_i(copy),
    .act_o(act), .rdata_o(cmp_rdata)
  );

  pwm_out_mux u_mux (
    .ctl_i(ctl), .wave_a_i(wave_a_i), .wave_b_i(wave_b_i),
    .out_a_o(out_a_o), .out_b_o(out_b_o), .out_c_o(out_c_o), .out_d_o(out_d_o)
  );

  assign rdata_o     = ctl_rdata | cmp_rdata;
  assign act_set_a_o = act[CH_SET_A];
  assign act_set_b_o = act[CH_SET_B];
  assign act_clr_a_o = act[CH_CLR_A];
  assign act_clr_b_o = act[CH_CLR_B];
endmodule

// File: tb/tb_pwm_shadow_ctrl.sv
`timescale 1ns/1ps
module tb_pwm_shadow_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic cyc_end = 1'b0;
  logic wa = 1'b0, wb = 1'b0;
  logic [11:0] sa, sb, ca, cb;
  logic oa, ob, oc, od;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_shadow_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cycle_end_i(cyc_end), .wave_a_i(wa), .wave_b_i(wb),
    .act_set_a_o(sa), .act_set_b_o(sb), .act_clr_a_o(ca), .act_clr_b_o(cb),
    .out_a_o(oa), .out_b_o(ob), .out_c_o(oc), .out_d_o(od)
  );

  task automatic chk(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h exp %0h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 0; cyc_end = 0; addr = 0; wdata = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic ce = 1'b0);
    addr = a; wdata = d; wr_en = 1'b1; cyc_end = ce;
    @(negedge clk);
    wr_en = 1'b0; cyc_end = 1'b0;
  endtask

  task automatic pulse_end();
    cyc_end = 1'b1;
    @(negedge clk);
    cyc_end = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input int exp, input string what);
    addr = a; wr_en = 1'b0;
    #1;
    chk(rdata, exp, what);
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    for (int a = 0; a < 16; a++) rd_chk(4'(a), 0, "R1 reset readback");
    chk(sa | sb | ca | cb, 0, "R1 active zero");
    wa = 1; wb = 0; #1;
    chk({oa, ob, oc, od}, 4'b1011, "R1 outputs follow waves");
    pulse_end();
    chk(sa | sb | ca | cb, 0, "R1 no pending after reset");
  endtask

  task automatic t_readback();
    do_reset();
    wr(4'h2, 8'hAB); wr(4'h3, 8'hFC);
    rd_chk(4'h2, 8'hAB, "R2 lo byte");
    rd_chk(4'h3, 8'h0C, "R2 hi byte masked");
    rd_chk(4'h4, 0, "R8 no mirror when fifty clear");
    rd_chk(4'h5, 0, "R8 no mirror hi when fifty clear");
    wr(4'h1, 8'h83);
    rd_chk(4'h1, 8'h03, "R5 strobe bit reads zero");
  endtask

  task automatic t_soft();
    do_reset();
    wr(4'h2, 8'hAB); wr(4'h3, 8'h0C); wr(4'h8, 8'h55); wr(4'h9, 8'h0F);
    pulse_end();
    chk(sa, 0, "R3 no transfer without request");
    wr(4'h1, 8'h80);
    chk(sa, 0, "R3 armed but no cycle end");
    pulse_end();
    chk(sa, 12'hCAB, "R4 set_a transfer");
    chk(cb, 12'hF55, "R4 clr_b transfer");
    chk(sb, 0, "R4 set_b transfer");
    wr(4'h2, 8'h00);
    pulse_end();
    chk(sa, 12'hCAB, "R4 request cleared after transfer");
  endtask

  task automatic t_auto();
    do_reset();
    wr(4'h0, 8'h02);
    wr(4'h8, 8'h34);
    pulse_end();
    chk(cb, 0, "R6 low byte does not arm");
    wr(4'h7, 8'h01);
    pulse_end();
    chk(ca, 0, "R6 clr_a hi does not arm without fifty");
    wr(4'h9, 8'h05);
    chk(cb, 0, "R3 held until cycle end");
    pulse_end();
    chk(cb, 12'h534, "R6 clr_b hi arms");
    chk(ca, 12'h100, "R6 clr_a carried");
  endtask

  task automatic t_fifty();
    do_reset();
    wr(4'h0, 8'h0A);
    wr(4'h4, 8'h11); wr(4'h5, 8'h02);
    rd_chk(4'h2, 8'h11, "R8 set lo mirrored");
    rd_chk(4'h3, 8'h02, "R8 set hi mirrored");
    wr(4'h6, 8'h77);
    rd_chk(4'h8, 8'h77, "R9 clr lo mirrored");
    pulse_end();
    chk(ca, 0, "R7 lo byte does not arm");
    wr(4'h7, 8'h03);
    rd_chk(4'h9, 8'h03, "R9 clr hi mirrored");
    pulse_end();
    chk(ca, 12'h377, "R7 clr_a hi arms");
    chk(cb, 12'h377, "R9 clr_b active");
    chk(sa, 12'h211, "R8 set_a active");
    chk(sb, 12'h211, "R8 set_b active");
  endtask

  task automatic t_route();
    do_reset();
    wa = 1; wb = 0;
    wr(4'h0, 8'h40); #1;
    chk({oc, od}, 2'b01, "R10 C from B, D from A");
    wr(4'h0, 8'h80); #1;
    chk({oc, od}, 2'b10, "R10 C from A, D from B");
    wr(4'h0, 8'hC0); wa = 0; wb = 1; #1;
    chk({oc, od}, 2'b11, "R10 both from B");
  endtask

  task automatic t_ovr();
    do_reset();
    wa = 1; wb = 0;
    wr(4'h1, 8'h02); #1;
    chk({oa, ob}, 2'b10, "R11 override off follows waves");
    wr(4'h0, 8'h01); #1;
    chk({oa, ob}, 2'b01, "R11 override levels");
    chk(oc, 1, "R10 C still from raw A");
    wr(4'h0, 8'h00); #1;
    chk({oa, ob}, 2'b10, "R11 override released");
  endtask

  task automatic t_rsv();
    do_reset();
    wr(4'h0, 8'hFF);
    rd_chk(4'h0, 8'hCB, "R12 reserved bits zero");
    wr(4'h0, 8'h34);
    rd_chk(4'h0, 8'h00, "R12 reserved-only write");
  endtask

  task automatic t_same_edge();
    do_reset();
    wr(4'h2, 8'h01);
    wr(4'h1, 8'h80);
    wr(4'h1, 8'h80, 1'b1);
    chk(sa, 12'h001, "R13 transfer on shared edge");
    wr(4'h2, 8'h02);
    pulse_end();
    chk(sa, 12'h002, "R13 new request kept");
  endtask

  initial begin
    t_reset();
    t_readback();
    t_soft();
    t_auto();
    t_fifty();
    t_route();
    t_ovr();
    t_rsv();
    t_same_edge();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule